// File: doc/BRIEF.md
# Bootstrap Charge Management Controller

This block sits between the per-phase gate requests of a bridge controller and the downstream dead-time stage. For each phase it watches two digital flags from an external comparator pair: one that says the bootstrap supply is below its undervoltage level, and one that says it has climbed back above that level plus hysteresis. When a high-side turn-on is requested while the bootstrap is low, or when the bootstrap sags while the high side is already conducting, the controller withholds the high-side gate. It forces the complementary low-side switch on so that the bootstrap capacitor recharges through the switch node.

A charge cycle always lasts at least a minimum number of clock cycles. It ends only on the upper hysteresis flag, or on withdrawal of the high-side request once the minimum has elapsed. If the upper flag never arrives within a timeout, the phase latches a fault and every gate output of the block is forced off until reset. Each phase has its own state machine, timer and fault bit. Durations are parameters in clock cycles.

The phase state machine has three states. PASS forwards the requests. CHARGE forces the low side on and runs the timer. FAULT holds every output off. Its transitions are:

- enter_charge: PASS to CHARGE.
- charged: CHARGE to PASS on the upper flag after the minimum.
- abandon: CHARGE to PASS on a dropped request after the minimum.
- time_out: CHARGE to FAULT.
- Reset: any state to PASS.

Top module: `boot_charge_mgr`

## Requirements
- R1: After reset with no requests, every gate output, charging flag and fault bit is 0.
- R2: In PASS, with the below-threshold flag low, the high-side output of a phase follows its high-side request and the low-side output follows its low-side request in the same cycle.
- R3: A phase never drives its high-side and low-side outputs together; when both requests are 1, the low side wins and the high side is 0.
- R4: In PASS, a high-side request (with no low-side request) seen together with the below-threshold flag gives high-side output 0 and low-side output 1 in that same cycle, and charging rises at the next clock edge (transition enter_charge).
- R5: A phase whose high side is conducting enters a charge cycle in the same way when its below-threshold flag rises.
- R6: A charge cycle keeps charging at 1, low-side output at 1 and high-side output at 0 for at least MIN_CYC cycles, even if the upper flag is already 1.
- R7: After the minimum, the cycle continues while the upper flag is 0, even with the below-threshold flag low. In the first charging cycle in which the upper flag is 1, the phase returns to PASS at the next edge (transition charged), and a still-asserted high-side request then turns the high side on.
- R8: Dropping the high-side request during a charge cycle ends it only once MIN_CYC charging cycles have passed (transition abandon).
- R9: If a charge cycle reaches TMO_CYC charging cycles without the upper flag, that phase's fault bit is 1 from the next edge (transition time_out), its charging flag is 0, and all gate outputs of all phases are 0.
- R10: A fault bit stays 1 whatever the inputs do, until rst_n is driven low.
- R11: Phases are independent: a charge cycle or fault in one phase does not change another phase's charging flag or fault bit, and a charge cycle does not change another phase's gate outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also the only way to clear faults |
| hi_req | input | NPH | Requested high-side gate state, one bit per phase |
| lo_req | input | NPH | Requested low-side gate state, one bit per phase |
| boot_low | input | NPH | Bootstrap below undervoltage level |
| boot_ok | input | NPH | Bootstrap above undervoltage level plus hysteresis |
| hi_out | output | NPH | High-side gate request to the dead-time stage |
| lo_out | output | NPH | Low-side gate request to the dead-time stage |
| charging | output | NPH | Phase is in a charge cycle |
| fault | output | NPH | Latched bootstrap fault per phase |

## Verification
The gate outputs are combinational in PASS, so they are due in the same cycle as the inputs. The charging and fault flags are registered and change one edge after the cycle that triggers them. A charge cycle lasts exactly MIN_CYC cycles when the upper flag is already present, and the fault appears one edge after the TMO_CYC-th charging cycle. The bench applies inputs 1 ns after a rising edge and pairs each stimulus cycle with the expected outputs of that same cycle, taken 3 ns after the edge. Multi-cycle windows are therefore checked cycle by cycle, counted from the triggering cycle.

// File: rtl/bcm_pkg.sv
package bcm_pkg;

    typedef enum logic [1:0] {
        PH_PASS   = 2'd0,
        PH_CHARGE = 2'd1,
        PH_FAULT  = 2'd2
    } bcm_state_e;

endpackage

// File: rtl/bcm_timer.sv
module bcm_timer #(
    parameter int unsigned MIN_CYC = 1750,
    parameter int unsigned TMO_CYC = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic min_done,
    output logic expired
);
    localparam int unsigned CW = $clog2(TMO_CYC + 1);
    localparam logic [CW-1:0] MIN_LAST = CW'(MIN_CYC - 1);
    localparam logic [CW-1:0] TMO_LAST = CW'(TMO_CYC - 1);

    logic [CW-1:0] cnt;

    // cnt holds the index of the current charging cycle, 0 on entry
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt != TMO_LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign min_done = run && (cnt >= MIN_LAST);
    assign expired  = run && (cnt == TMO_LAST);

endmodule

// File: rtl/bcm_phase_fsm.sv
module bcm_phase_fsm
    import bcm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hi_req,
    input  logic lo_req,
    input  logic boot_low,
    input  logic boot_ok,
    input  logic min_done,
    input  logic expired,
    output logic hi_g,
    output logic lo_g,
    output logic run,
    output logic flt
);
    bcm_state_e state, nxt;
    logic       want_hi;

    assign want_hi = hi_req && !lo_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PH_PASS;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            PH_PASS: begin
                if (want_hi && boot_low) begin
                    nxt = PH_CHARGE;              // enter_charge
                end
            end
            PH_CHARGE: begin
                if (expired) begin
                    nxt = PH_FAULT;               // time_out
                end else if (min_done && boot_ok) begin
                    nxt = PH_PASS;                // charged
                end else if (min_done && !hi_req) begin
                    nxt = PH_PASS;                // abandon
                end
            end
            PH_FAULT: begin
                nxt = PH_FAULT;
            end
            default: begin
                nxt = PH_FAULT;
            end
        endcase
    end

    always_comb begin
        hi_g = 1'b0;
        lo_g = 1'b0;
        run  = 1'b0;
        flt  = 1'b0;
        unique case (state)
            PH_PASS: begin
                hi_g = want_hi && !boot_low;
                lo_g = lo_req || (want_hi && boot_low);
            end
            PH_CHARGE: begin
                lo_g = 1'b1;
                run  = 1'b1;
            end
            PH_FAULT: begin
                flt  = 1'b1;
            end
            default: begin
                flt  = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/boot_charge_mgr.sv
module boot_charge_mgr #(
    parameter int unsigned NPH     = 2,
    parameter int unsigned MIN_CYC = 1750,
    parameter int unsigned TMO_CYC = 50000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NPH-1:0] hi_req,
    input  logic [NPH-1:0] lo_req,
    input  logic [NPH-1:0] boot_low,
    input  logic [NPH-1:0] boot_ok,
    output logic [NPH-1:0] hi_out,
    output logic [NPH-1:0] lo_out,
    output logic [NPH-1:0] charging,
    output logic [NPH-1:0] fault
);
    logic [NPH-1:0] hi_g, lo_g, min_done, expired;
    logic           kill;

    for (genvar p = 0; p < NPH; p++) begin : g_ph
        bcm_timer #(
            .MIN_CYC (MIN_CYC),
            .TMO_CYC (TMO_CYC)
        ) u_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (charging[p]),
            .min_done (min_done[p]),
            .expired  (expired[p])
        );

        bcm_phase_fsm u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .hi_req   (hi_req[p]),
            .lo_req   (lo_req[p]),
            .boot_low (boot_low[p]),
            .boot_ok  (boot_ok[p]),
            .min_done (min_done[p]),
            .expired  (expired[p]),
            .hi_g     (hi_g[p]),
            .lo_g     (lo_g[p]),
            .run      (charging[p]),
            .flt      (fault[p])
        );
    end

    // a latched fault in any phase disables the whole bridge
    assign kill   = |fault;
    assign hi_out = kill ? '0 : hi_g;
    assign lo_out = kill ? '0 : lo_g;

endmodule

// File: rtl/bcm_checker.sv
module bcm_checker #(
    parameter int unsigned NPH     = 2,
    parameter int unsigned MIN_CYC = 1750,
    parameter int unsigned TMO_CYC = 50000
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NPH-1:0] boot_low,
    input logic [NPH-1:0] hi_out,
    input logic [NPH-1:0] lo_out,
    input logic [NPH-1:0] charging,
    input logic [NPH-1:0] fault
);
    localparam int unsigned RW = $clog2(TMO_CYC + 2);

    for (genvar p = 0; p < NPH; p++) begin : g_chk
        logic [RW-1:0] run_len;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                run_len <= '0;
            end else if (charging[p]) begin
                run_len <= run_len + 1'b1;
            end else begin
                run_len <= '0;
            end
        end

        assert_no_shoot_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !(hi_out[p] && lo_out[p]));

        assert_hi_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
            hi_out[p] |-> !boot_low[p]);

        assert_charge_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (charging[p] && !(|fault)) |-> (lo_out[p] && !hi_out[p]));

        assert_min_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(charging[p]) && !fault[p]) |-> (run_len >= RW'(MIN_CYC)));

        assert_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
            run_len <= RW'(TMO_CYC));

        assert_fault_sticks_R10: assert property (@(posedge clk) disable iff (!rst_n)
            fault[p] |=> fault[p]);
    end

    assert_fault_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|fault) |-> (hi_out == '0 && lo_out == '0));

endmodule

bind boot_charge_mgr bcm_checker #(
    .NPH     (NPH),
    .MIN_CYC (MIN_CYC),
    .TMO_CYC (TMO_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .boot_low (boot_low),
    .hi_out   (hi_out),
    .lo_out   (lo_out),
    .charging (charging),
    .fault    (fault)
);

// File: tb/sim_boot_charge_mgr.sv
module sim_boot_charge_mgr;
    localparam int MINC = 6;
    localparam int TMOC = 30;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] hi_req = '0, lo_req = '0, boot_low = '0, boot_ok = '0;
    logic [1:0] hi_out, lo_out, charging, fault;

    always #2 clk = ~clk;

    boot_charge_mgr #(.NPH(2), .MIN_CYC(MINC), .TMO_CYC(TMOC)) u0 (
        .clk(clk), .rst_n(rst_n), .hi_req(hi_req), .lo_req(lo_req),
        .boot_low(boot_low), .boot_ok(boot_ok), .hi_out(hi_out),
        .lo_out(lo_out), .charging(charging), .fault(fault)
    );

    typedef struct {
        string      tag;
        logic [1:0] hi, lo, chg, flt;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0, n_bad = 0;
    bit   done = 0;

    // driver: applies one cycle of stimulus and queues what that cycle must show
    task automatic step(input logic [1:0] hr, lr, bl, bo,
                        input logic [1:0] ehi, elo, echg, eflt, input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        hi_req = hr; lo_req = lr; boot_low = bl; boot_ok = bo;
        e.tag = tag; e.hi = ehi; e.lo = elo; e.chg = echg; e.flt = eflt;
        q.push_back(e);
    endtask

    task automatic do_reset();
        @(posedge clk);
        #1;
        rst_n = 1'b0;
        hi_req = '0; lo_req = '0; boot_low = '0; boot_ok = 2'b11;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    // monitor: compares each queued item 3 ns after the edge
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_chk++;
                if (hi_out !== e.hi || lo_out !== e.lo || charging !== e.chg || fault !== e.flt) begin
                    n_bad++;
                    $display("FAIL %s: hi/lo/chg/flt got %b/%b/%b/%b expected %b/%b/%b/%b",
                             e.tag, hi_out, lo_out, charging, fault, e.hi, e.lo, e.chg, e.flt);
                end
            end
        end
    end

    initial begin
        #100000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hung expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        step(2'b00, 2'b00, 2'b00, 2'b11, 2'b00, 2'b00, 2'b00, 2'b00, "R1 reset");
        // R2 pass-through
        step(2'b01, 2'b00, 2'b00, 2'b11, 2'b01, 2'b00, 2'b00, 2'b00, "R2 hi0");
        step(2'b00, 2'b10, 2'b00, 2'b11, 2'b00, 2'b10, 2'b00, 2'b00, "R2 lo1");
        step(2'b10, 2'b00, 2'b00, 2'b11, 2'b10, 2'b00, 2'b00, 2'b00, "R2 hi1");
        // R3 both requested: low wins
        step(2'b01, 2'b01, 2'b00, 2'b11, 2'b00, 2'b01, 2'b00, 2'b00, "R3 lockout");
        // R4 request into a low bootstrap, then R7 hysteresis
        step(2'b01, 2'b00, 2'b01, 2'b10, 2'b00, 2'b01, 2'b00, 2'b00, "R4 entry");
        for (int i = 0; i < MINC + 3; i++)
            step(2'b01, 2'b00, 2'b00, 2'b10, 2'b00, 2'b01, 2'b01, 2'b00, "R7 hold in hysteresis");
        step(2'b01, 2'b00, 2'b00, 2'b11, 2'b00, 2'b01, 2'b01, 2'b00, "R7 exit cycle");
        step(2'b01, 2'b00, 2'b00, 2'b11, 2'b01, 2'b00, 2'b00, 2'b00, "R7 high restored");
        step(2'b00, 2'b00, 2'b00, 2'b11, 2'b00, 2'b00, 2'b00, 2'b00, "R2 idle");
        // R6 minimum time with upper flag already present
        step(2'b01, 2'b00, 2'b01, 2'b10, 2'b00, 2'b01, 2'b00, 2'b00, "R4 entry2");
        for (int i = 0; i < MINC; i++)
            step(2'b01, 2'b00, 2'b00, 2'b11, 2'b00, 2'b01, 2'b01, 2'b00, "R6 minimum");
        step(2'b01, 2'b00, 2'b00, 2'b11, 2'b01, 2'b00, 2'b00, 2'b00, "R6 ends after minimum");
        // R5 sag while high side conducts
        step(2'b01, 2'b00, 2'b01, 2'b10, 2'b00, 2'b01, 2'b00, 2'b00, "R5 sag");
        for (int i = 0; i < MINC; i++)
            step(2'b01, 2'b00, 2'b00, 2'b11, 2'b00, 2'b01, 2'b01, 2'b00, "R5 recharge");
        step(2'b01, 2'b00, 2'b00, 2'b11, 2'b01, 2'b00, 2'b00, 2'b00, "R5 resumes");
        // R8 abandon only after minimum
        step(2'b01, 2'b00, 2'b01, 2'b10, 2'b00, 2'b01, 2'b00, 2'b00, "R8 entry");
        for (int i = 0; i < MINC; i++)
            step(2'b00, 2'b00, 2'b00, 2'b10, 2'b00, 2'b01, 2'b01, 2'b00, "R8 request dropped");
        step(2'b00, 2'b00, 2'b00, 2'b10, 2'b00, 2'b00, 2'b00, 2'b00, "R8 abandoned");
        // R11 phase 1 charges while phase 0 conducts
        step(2'b11, 2'b00, 2'b10, 2'b01, 2'b01, 2'b10, 2'b00, 2'b00, "R11 entry ph1");
        for (int i = 0; i < MINC; i++)
            step(2'b11, 2'b00, 2'b00, 2'b11, 2'b01, 2'b10, 2'b10, 2'b00, "R11 ph0 unaffected");
        step(2'b11, 2'b00, 2'b00, 2'b11, 2'b11, 2'b00, 2'b00, 2'b00, "R11 both high");
        // R9 timeout on phase 1
        step(2'b11, 2'b00, 2'b10, 2'b01, 2'b01, 2'b10, 2'b00, 2'b00, "R9 entry");
        for (int i = 0; i < TMOC; i++)
            step(2'b11, 2'b00, 2'b00, 2'b01, 2'b01, 2'b10, 2'b10, 2'b00, "R9 before timeout");
        step(2'b11, 2'b00, 2'b00, 2'b01, 2'b00, 2'b00, 2'b00, 2'b10, "R9 fault all off");
        // R10 latched regardless of inputs
        step(2'b11, 2'b00, 2'b00, 2'b11, 2'b00, 2'b00, 2'b00, 2'b10, "R10 boot recovered");
        step(2'b00, 2'b11, 2'b00, 2'b11, 2'b00, 2'b00, 2'b00, 2'b10, "R10 low request");
        step(2'b00, 2'b00, 2'b00, 2'b11, 2'b00, 2'b00, 2'b00, 2'b10, "R10 idle");
        do_reset();
        step(2'b00, 2'b00, 2'b00, 2'b11, 2'b00, 2'b00, 2'b00, 2'b00, "R10 cleared by reset");
        step(2'b11, 2'b00, 2'b00, 2'b11, 2'b11, 2'b00, 2'b00, 2'b00, "R10 operating again");
        @(posedge clk);
        @(posedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule